// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC-V Subset Core

This block is a 32-bit processor core that retires exactly one instruction on every rising clock edge. It implements a small RISC-V integer subset: register-to-register add, subtract, AND and OR, a word load, a word store, and a branch taken when two registers are equal. Instructions and data live in two separate on-block word arrays, so an instruction fetch and a data access never compete for the same storage. The environment fills both arrays before it releases reset.

Each cycle runs the whole path in one clock period. The program counter addresses the instruction array. A main decoder and an ALU-function decoder set up the datapath. The register file supplies operands, and the immediate generator sign-extends the offset field. The ALU result then goes to the register file, to the data array address, or to the branch decision.

A debug port shows the current program counter. It also returns any register selected by a 5-bit index, which is the normal way to observe results.

Top module: `rv_sc_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC is cleared to 0 and every register is cleared to 0. No register or data-array write takes place during reset.
- R2: After an instruction that is not a taken branch, the PC is the previous PC plus 4.
- R3: The R-type opcode is 0110011. With funct3 000, bit 30 of the instruction clear gives rd = rs1 + rs2 and bit 30 set gives rd = rs1 − rs2, both modulo 2^32.
- R4: An R-type instruction with funct3 111 gives rd = rs1 AND rs2. An R-type instruction with funct3 110 gives rd = rs1 OR rs2.
- R5: Register 0 always reads as 0. Any instruction naming it as destination leaves it at 0.
- R6: A load (opcode 0000011, funct3 010) writes rd with the data word at byte address rs1 + sign-extended bits [31:20]. The offset may be negative.
- R7: A store (opcode 0100011, funct3 010) writes rs2 to the data word at byte address rs1 + sign-extended {bits[31:25], bits[11:7]}. The new value is visible to a load in any later cycle.
- R8: A branch (opcode 1100011, funct3 000) with rs1 == rs2 sets the PC to PC + (sign-extended 12-bit offset {bit31, bit7, bits[30:25], bits[11:8]} shifted left by 1). Backward offsets are allowed.
- R9: A branch whose two operands differ advances the PC by 4.
- R10: Any other opcode writes no register and no data word, and advances the PC by 4.
- R11: Register and data writes take effect at the rising edge. The debug register read and the data-array read are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_reg_sel | input | 5 | Index of the register shown on `dbg_reg_data` |
| dbg_reg_data | output | 32 | Combinational value of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The bench builds the core with 32-word instruction and data arrays. This size lets every word be cleared or preloaded between scenarios. Address arithmetic then wraps within a small space, so positive and negative load and store offsets can reach the same words from different base registers. The branch scenario runs forward-taken, backward-taken and not-taken cases in one program, and the bench samples the PC after each step. A final scenario feeds encodings outside the subset and confirms that they leave the destination register unchanged.

// File: rtl/rv_sc_pkg.sv
// Package: shared widths, opcode values and decode types for the
// single-cycle core. Assumes a 32-bit data path and 32 registers.
package rv_sc_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int REG_AW = $clog2(NREGS);

    localparam logic [6:0] OPC_RTYPE  = 7'b0110011;
    localparam logic [6:0] OPC_LOAD   = 7'b0000011;
    localparam logic [6:0] OPC_STORE  = 7'b0100011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    // 2-bit code from the main decoder to the ALU-function decoder
    typedef enum logic [1:0] {
        AOP_ADDR  = 2'b00,
        AOP_CMP   = 2'b01,
        AOP_FUNCT = 2'b10,
        AOP_SPARE = 2'b11
    } alu_class_e;

    // 4-bit operation code seen by the ALU
    typedef enum logic [3:0] {
        FN_AND = 4'b0000,
        FN_OR  = 4'b0001,
        FN_ADD = 4'b0010,
        FN_SUB = 4'b0110
    } alu_fn_e;

    typedef enum logic [1:0] {
        IMMK_LOAD   = 2'b00,
        IMMK_STORE  = 2'b01,
        IMMK_BRANCH = 2'b10
    } imm_kind_e;

    typedef struct packed {
        logic       reg_we;
        logic       mem_we;
        logic       mem_to_reg;
        logic       use_imm;
        logic       is_branch;
        alu_class_e alu_class;
        imm_kind_e  imm_kind;
    } ctrl_t;

endpackage

// File: rtl/rv_word_mem.sv
// Word-organised array with a combinational read and a write on the
// rising edge. Addresses are byte addresses: the two low bits are
// ignored and the index wraps modulo WORDS. WORDS must be a power of 2.
module rv_word_mem #(
    parameter int WORDS = 64,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             we,
    input  logic [WIDTH-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int AW = $clog2(WORDS);

    logic [WIDTH-1:0] mem_q [WORDS];
    logic [AW-1:0]    idx;
    logic             unused_addr_bits;

    // word index taken from the byte address
    assign idx              = addr[AW+1:2];
    assign unused_addr_bits = ^{addr[1:0], addr[WIDTH-1:AW+2]};

    // combinational read port
    assign rdata = mem_q[idx];

    // single write port, updated on the rising edge
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[idx] <= wdata;
        end
    end
endmodule

// File: rtl/rv_regfile.sv
// Register file with two operand read ports, one debug read port and one
// write port. Reads are combinational and writes happen on the rising
// edge. Register 0 is never written. A synchronous active-low reset
// clears all registers.
module rv_regfile
    import rv_sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] rs1_idx,
    input  logic [REG_AW-1:0] rs2_idx,
    input  logic [REG_AW-1:0] dbg_idx,
    output logic [XLEN-1:0]   rs1_val,
    output logic [XLEN-1:0]   rs2_val,
    output logic [XLEN-1:0]   dbg_val,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_val
);
    logic [XLEN-1:0] regs_q [NREGS];

    // combinational read ports
    assign rs1_val = regs_q[rs1_idx];
    assign rs2_val = regs_q[rs2_idx];
    assign dbg_val = regs_q[dbg_idx];

    // clear on reset, otherwise write any register except index 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            regs_q[wr_idx] <= wr_val;
        end
    end

    // register 0 keeps its reset value whatever the write port does
    assert_x0_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[0] == '0);

    // a write to a non-zero register lands at the next edge
    assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != '0) |=> (regs_q[$past(wr_idx)] == $past(wr_val)));
endmodule

// File: rtl/rv_decode.sv
// Two-level decoder. The main stage maps the opcode to datapath controls
// and a 2-bit ALU class. The second stage combines that class with funct3
// and instruction bit 30 to give the 4-bit ALU function. Opcodes outside
// the subset produce no write and no branch.
module rv_decode
    import rv_sc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [6:0] opcode,
    input  logic [2:0] funct3,
    input  logic       bit30,
    output ctrl_t      ctrl,
    output alu_fn_e    alu_fn
);
    // main control: opcode to datapath steering
    always_comb begin
        ctrl           = '0;
        ctrl.alu_class = AOP_ADDR;
        ctrl.imm_kind  = IMMK_LOAD;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.reg_we    = 1'b1;
                ctrl.alu_class = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctrl.reg_we     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.use_imm    = 1'b1;
                ctrl.imm_kind   = IMMK_LOAD;
            end
            OPC_STORE: begin
                ctrl.mem_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMMK_STORE;
            end
            OPC_BRANCH: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_class = AOP_CMP;
                ctrl.imm_kind  = IMMK_BRANCH;
            end
            default: ;
        endcase
    end

    // ALU control: class plus function bits to ALU operation
    always_comb begin
        alu_fn = FN_ADD;
        unique case (ctrl.alu_class)
            AOP_ADDR:  alu_fn = FN_ADD;
            AOP_CMP:   alu_fn = FN_SUB;
            AOP_FUNCT: begin
                unique case (funct3)
                    3'b000:  alu_fn = bit30 ? FN_SUB : FN_ADD;
                    3'b111:  alu_fn = FN_AND;
                    3'b110:  alu_fn = FN_OR;
                    default: alu_fn = FN_ADD;
                endcase
            end
            default:   alu_fn = FN_ADD;
        endcase
    end

    // at most one kind of architectural effect per instruction
    assert_single_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl.reg_we & ~ctrl.mem_to_reg, ctrl.mem_to_reg, ctrl.mem_we, ctrl.is_branch}));

    // memory accesses always form their address with an add
    assert_addr_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.mem_we || ctrl.mem_to_reg) |-> (alu_fn == FN_ADD));

    // branches always compare by subtraction
    assert_branch_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.is_branch |-> (alu_fn == FN_SUB));
endmodule

// File: rtl/rv_immgen.sv
// Immediate generator. Assembles the 12-bit offset field for the selected
// format and sign-extends it to XLEN. The branch offset is returned
// unshifted; the caller applies the left shift.
module rv_immgen
    import rv_sc_pkg::*;
(
    input  logic [31:7]     instr_hi,
    input  imm_kind_e       kind,
    output logic [XLEN-1:0] imm
);
    logic [11:0] field;

    // pick the offset bits for the instruction format
    always_comb begin
        unique case (kind)
            IMMK_STORE:  field = {instr_hi[31:25], instr_hi[11:7]};
            IMMK_BRANCH: field = {instr_hi[31], instr_hi[7], instr_hi[30:25], instr_hi[11:8]};
            default:     field = instr_hi[31:20];
        endcase
    end

    // sign extension
    assign imm = {{(XLEN-12){field[11]}}, field};
endmodule

// File: rtl/rv_alu.sv
// Four-function ALU with a zero flag. Unknown function codes add.
module rv_alu
    import rv_sc_pkg::*;
(
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    // operation select
    always_comb begin
        unique case (fn)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_SUB:  y = a - b;
            default: y = a + b;
        endcase
    end

    // zero flag steers the branch decision
    assign zero = (y == '0);
endmodule

// File: rtl/rv_sc_core.sv
// Top of the single-cycle core. Holds the PC and wires the fetch, decode,
// register, ALU and data-access path so that one instruction completes
// per rising edge. Both arrays are filled by the environment while reset
// is held. Synchronous active-low reset.
module rv_sc_core
    import rv_sc_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] dbg_reg_sel,
    output logic [XLEN-1:0]   dbg_reg_data,
    output logic [XLEN-1:0]   dbg_pc
);
    logic [XLEN-1:0] pc_q, pc_plus4, br_target, next_pc;
    logic [XLEN-1:0] instr, rs1_val, rs2_val, imm, alu_b, alu_y;
    logic [XLEN-1:0] dmem_rdata, wb_val;
    logic            alu_zero, take_branch;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;

    // instruction array: read-only during execution
    rv_word_mem #(.WORDS(IMEM_WORDS), .WIDTH(XLEN)) u_imem (
        .clk   (clk),
        .we    (1'b0),
        .addr  (pc_q),
        .wdata ('0),
        .rdata (instr)
    );

    rv_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (instr[6:0]),
        .funct3 (instr[14:12]),
        .bit30  (instr[30]),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    rv_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rs1_idx (instr[19:15]),
        .rs2_idx (instr[24:20]),
        .dbg_idx (dbg_reg_sel),
        .rs1_val (rs1_val),
        .rs2_val (rs2_val),
        .dbg_val (dbg_reg_data),
        .wr_en   (ctrl.reg_we & rst_n),
        .wr_idx  (instr[11:7]),
        .wr_val  (wb_val)
    );

    rv_immgen u_imm (
        .instr_hi (instr[31:7]),
        .kind     (ctrl.imm_kind),
        .imm      (imm)
    );

    // second ALU operand: register or immediate
    assign alu_b = ctrl.use_imm ? imm : rs2_val;

    rv_alu u_alu (
        .fn   (alu_fn),
        .a    (rs1_val),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data array, separate from the instruction array
    rv_word_mem #(.WORDS(DMEM_WORDS), .WIDTH(XLEN)) u_dmem (
        .clk   (clk),
        .we    (ctrl.mem_we & rst_n),
        .addr  (alu_y),
        .wdata (rs2_val),
        .rdata (dmem_rdata)
    );

    // write-back source select
    assign wb_val = ctrl.mem_to_reg ? dmem_rdata : alu_y;

    // next-PC adders and the zero-steered choice between them
    assign pc_plus4    = pc_q + XLEN'(4);
    assign br_target   = pc_q + {imm[XLEN-2:0], 1'b0};
    assign take_branch = ctrl.is_branch & alu_zero;
    assign next_pc     = take_branch ? br_target : pc_plus4;

    // program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= next_pc;
    end

    assign dbg_pc = pc_q;

    // sequential step when no branch was taken
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(take_branch)) |-> (pc_q == $past(pc_q) + XLEN'(4)));

    // taken branch lands on PC plus doubled offset
    assert_branch_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch |=> (pc_q == $past(pc_q) + {$past(imm[XLEN-2:0]), 1'b0}));

    // instruction addresses stay word aligned
    assert_pc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);
endmodule

// File: tb/rv_sc_core_tb_top.sv
// Directed bench: each task loads a program, runs it and checks results
// through the debug port.
module rv_sc_core_tb_top;
    localparam int IW = 32;
    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data, dbg_pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    rv_sc_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_reg_data (dbg_reg_data),
        .dbg_pc       (dbg_pc)
    );

    always #10 clk = ~clk;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2, input int rs1,
                                          input logic [2:0] f3, input int rd);
        return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_lw(input int rd, input int rs1, input int off);
        logic [11:0] o = 12'(off);
        return {o, 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
    endfunction

    function automatic logic [31:0] enc_sw(input int rs2, input int rs1, input int off);
        logic [11:0] o = 12'(off);
        return {o[11:5], 5'(rs2), 5'(rs1), 3'b010, o[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_beq(input int rs1, input int rs2, input int off);
        logic [12:0] o = 13'(off);
        return {o[12], o[10:5], 5'(rs2), 5'(rs1), 3'b000, o[4:1], o[11], 7'b1100011};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int idx, output logic [31:0] val);
        dbg_reg_sel = 5'(idx);
        #1;
        val = dbg_reg_data;
    endtask

    task automatic check_reg(input string req, input int idx, input logic [31:0] exp);
        logic [31:0] v;
        read_reg(idx, v);
        check(req, v, exp);
    endtask

    // hold reset, clear both arrays; programs are written afterwards
    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < IW; i++) dut_i.u_imem.mem_q[i] = 32'h0;
        for (int i = 0; i < DW; i++) dut_i.u_dmem.mem_q[i] = 32'h0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // R3, R4, R2: arithmetic and logic on loaded operands
    task automatic test_arith();
        logic [31:0] a = 32'h1234_5678;
        logic [31:0] b = 32'h0F0F_00FF;
        enter_reset();
        dut_i.u_dmem.mem_q[1] = a;
        dut_i.u_dmem.mem_q[2] = b;
        dut_i.u_imem.mem_q[0] = enc_lw(1, 0, 4);
        dut_i.u_imem.mem_q[1] = enc_lw(2, 0, 8);
        dut_i.u_imem.mem_q[2] = enc_r(7'h00, 2, 1, 3'b000, 3);
        dut_i.u_imem.mem_q[3] = enc_r(7'h20, 2, 1, 3'b000, 4);
        dut_i.u_imem.mem_q[4] = enc_r(7'h00, 2, 1, 3'b111, 5);
        dut_i.u_imem.mem_q[5] = enc_r(7'h00, 2, 1, 3'b110, 6);
        dut_i.u_imem.mem_q[6] = enc_r(7'h20, 1, 2, 3'b000, 7);
        release_reset();
        for (int k = 1; k <= 7; k++) begin
            run(1);
            check("R2 pc step", dbg_pc, 32'(4 * k));
        end
        check_reg("R3 add", 3, a + b);
        check_reg("R3 sub", 4, a - b);
        check_reg("R4 and", 5, a & b);
        check_reg("R4 or", 6, a | b);
        check_reg("R3 sub wrap", 7, b - a);
    endtask

    // R1: reset after a run clears PC and every register
    task automatic test_reset();
        @(negedge clk);
        rst_n = 1'b0;
        run(2);
        check("R1 pc", dbg_pc, 32'h0);
        for (int i = 0; i < 32; i++) check_reg("R1 reg clear", i, 32'h0);
        run(2);
        check("R1 pc held", dbg_pc, 32'h0);
    endtask

    // R5: register 0 ignores writes and reads as zero
    task automatic test_x0();
        enter_reset();
        dut_i.u_dmem.mem_q[1] = 32'hDEAD_BEEF;
        dut_i.u_imem.mem_q[0] = enc_lw(1, 0, 4);
        dut_i.u_imem.mem_q[1] = enc_lw(0, 0, 4);
        dut_i.u_imem.mem_q[2] = enc_r(7'h00, 1, 1, 3'b000, 0);
        dut_i.u_imem.mem_q[3] = enc_r(7'h00, 1, 0, 3'b000, 8);
        release_reset();
        run(2);
        check_reg("R5 after load to x0", 0, 32'h0);
        run(2);
        check_reg("R5 after add to x0", 0, 32'h0);
        check_reg("R5 x0 operand", 8, 32'hDEAD_BEEF);
    endtask

    // R6, R7, R11: load/store with positive and negative offsets
    task automatic test_mem();
        enter_reset();
        dut_i.u_dmem.mem_q[10] = 32'd32;
        dut_i.u_dmem.mem_q[6]  = 32'hCAFE_BABE;
        dut_i.u_imem.mem_q[0] = enc_lw(1, 0, 40);
        dut_i.u_imem.mem_q[1] = enc_lw(2, 1, -8);
        dut_i.u_imem.mem_q[2] = enc_lw(5, 0, 28);
        dut_i.u_imem.mem_q[3] = enc_sw(2, 1, -4);
        dut_i.u_imem.mem_q[4] = enc_lw(3, 0, 28);
        dut_i.u_imem.mem_q[5] = enc_sw(1, 1, 12);
        dut_i.u_imem.mem_q[6] = enc_lw(4, 0, 44);
        release_reset();
        run(1);
        check_reg("R6 positive offset", 1, 32'd32);
        run(1);
        check_reg("R6 negative offset", 2, 32'hCAFE_BABE);
        run(1);
        check_reg("R7 word before store", 5, 32'h0);
        run(2);
        check_reg("R7 negative store offset / R11", 3, 32'hCAFE_BABE);
        run(2);
        check_reg("R7 positive store offset", 4, 32'd32);
    endtask

    // R8, R9: not taken, forward taken, backward taken
    task automatic test_branch();
        enter_reset();
        dut_i.u_dmem.mem_q[1] = 32'd5;
        dut_i.u_dmem.mem_q[2] = 32'd5;
        dut_i.u_dmem.mem_q[3] = 32'd9;
        dut_i.u_imem.mem_q[0] = enc_lw(1, 0, 4);
        dut_i.u_imem.mem_q[1] = enc_lw(2, 0, 8);
        dut_i.u_imem.mem_q[2] = enc_lw(3, 0, 12);
        dut_i.u_imem.mem_q[3] = enc_beq(1, 3, 8);
        dut_i.u_imem.mem_q[4] = enc_beq(1, 2, 12);
        dut_i.u_imem.mem_q[5] = enc_lw(4, 0, 4);
        dut_i.u_imem.mem_q[6] = enc_lw(6, 0, 12);
        dut_i.u_imem.mem_q[7] = enc_beq(4, 0, -8);
        dut_i.u_imem.mem_q[8] = enc_r(7'h00, 3, 1, 3'b000, 7);
        release_reset();
        run(4);
        check("R9 not taken", dbg_pc, 32'd16);
        run(1);
        check("R8 forward taken", dbg_pc, 32'd28);
        run(1);
        check("R8 backward taken", dbg_pc, 32'd20);
        run(4);
        check("R9 not taken after loop", dbg_pc, 32'd36);
        check_reg("R8 skipped body ran once", 4, 32'd5);
        check_reg("R8 loop body", 6, 32'd9);
        check_reg("R9 fall-through add", 7, 32'd14);
    endtask

    // R10: encodings outside the subset have no effect
    task automatic test_unknown();
        enter_reset();
        dut_i.u_dmem.mem_q[0] = 32'h0000_0055;
        dut_i.u_dmem.mem_q[5] = 32'h0000_0077;
        dut_i.u_imem.mem_q[0] = enc_lw(1, 0, 4);
        dut_i.u_imem.mem_q[1] = {12'd4, 5'd1, 3'b000, 5'd2, 7'b0010011};
        dut_i.u_imem.mem_q[2] = 32'h0000_0000;
        dut_i.u_imem.mem_q[3] = {20'h12345, 5'd9, 7'b0110111};
        dut_i.u_imem.mem_q[4] = enc_lw(3, 0, 0);
        dut_i.u_imem.mem_q[5] = enc_lw(10, 0, 20);
        release_reset();
        run(4);
        check("R10 pc advance", dbg_pc, 32'd16);
        check_reg("R10 no write rd2", 2, 32'h0);
        check_reg("R10 no write rd9", 9, 32'h0);
        run(2);
        check_reg("R10 data word 0 intact", 3, 32'h0000_0055);
        check_reg("R10 data word 5 intact", 10, 32'h0000_0077);
    endtask

    initial begin
        rst_n = 1'b0;
        run(2);
        check("R1 pc at start", dbg_pc, 32'h0);
        test_arith();
        test_reset();
        test_x0();
        test_mem();
        test_branch();
        test_unknown();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule